// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel, together with the live pixel column and row counters and a one-cycle line interrupt. It runs on the pixel clock. A small word-addressed register port sets it up. Fetching pixels, layering and the pad electronics are handled elsewhere. The register port has a write strobe, a 3-bit word address, 32-bit write data and a combinational read-data bus.

The timing is given as cumulative boundaries counted from the start of a line or frame:

- the sync extent, which is the sync width minus one;
- that value plus the back porch;
- that value plus the active span;
- that value plus the front porch, which is the last count of the line or frame.

The timing registers and the line-interrupt position are written into a pending set. They reach the working set only when a reload happens. A reload is either immediate, or armed to happen at the end of the current frame, so new timing never takes effect in the middle of a frame. The control register acts at once. It holds the global enable, the output polarities and the pixel-clock inversion flag.

Top module: `disp_timing_gen`

## Requirements
- R1: Word addresses 0 (sync), 1 (back porch), 2 (active) and 3 (total) each hold a horizontal boundary in bits 27:16 (12 bits) and a vertical boundary in bits 10:0 (11 bits). A write stores the value in the pending set, and a read returns the pending value.
- R2: Writes to addresses 0–3 and to the line-interrupt position (address 6, bits 10:0) do not change the generated timing until a reload copies the pending set into the working set.
- R3: Writing address 5 with bit 0 set copies the whole pending set into the working set at that clock edge. Bit 0 always reads back 0.
- R4: Writing address 5 with bit 1 set arms a frame-end reload, and bit 1 reads 1 while armed. On the clock edge that ends a frame while enabled (column at the total width and row at the total height), the pending set is copied and the arm clears.
- R5: With control bit 0 (address 4) set, the column counts 0 up to the total-width boundary and then wraps to 0 and advances the row. The row wraps to 0 after the total-height boundary. With bit 0 clear, both counters are held at 0, so enabling starts from column 0, row 0 on the enabling edge.
- R6: Horizontal sync is active while column ≤ horizontal sync boundary. Vertical sync is active while row ≤ vertical sync boundary.
- R7: Data enable is active while back-porch boundary < column ≤ active boundary horizontally, and the same condition holds on the row with the vertical boundaries.
- R8: Control bit 31 set makes hsync active-high, otherwise it is active-low. Bit 30 does the same for vsync. Bit 29 set makes data enable active-low, otherwise it is active-high. While disabled, all three outputs sit at their inactive level.
- R9: The pixel-clock inversion output equals control bit 28.
- R10: While enabled, the line interrupt is high for exactly the one cycle in which the column is 0 and the row equals the working line-interrupt position.
- R11: Reading address 7 returns the live column in bits 27:16 and the live row in bits 10:0, with all other bits 0.
- R12: After reset, every register reads 0, the generator is disabled, and the counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| hsync | output | 1 | Horizontal sync, programmable polarity |
| vsync | output | 1 | Vertical sync, programmable polarity |
| de | output | 1 | Data enable, programmable polarity |
| pclk_invert | output | 1 | Request to invert the panel pixel clock |
| pix_x | output | 12 | Live column counter |
| pix_y | output | 11 | Live row counter |
| line_irq | output | 1 | One-cycle line interrupt |

## Verification
Counter outputs move on the clock edge, and sync, data enable, the line interrupt and the position read-back follow combinationally from the counters in the same cycle. The bench therefore drives every write at a falling edge and samples at the next falling edge. The edge that accepts the enabling write is counted as cycle k = 0, so column = k mod line length with no extra offset.

An immediate reload is seen at the sample right after the reload write. A frame-end reload keeps the old timing for exactly one full frame and applies the new one from the sample after the frame's last pixel. The bench's arithmetic model switches configuration at that exact index.

Register read-backs are taken a delay after setting the address, with no clock edge between.

// File: rtl/dtg_pkg.sv
// Shared constants for the display timing generator: register word
// addresses, field positions and control bit positions.
package dtg_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_SYNC   = 3'd0,
        A_PORCH  = 3'd1,
        A_ACTIVE = 3'd2,
        A_TOTAL  = 3'd3,
        A_CTRL   = 3'd4,
        A_RELOAD = 3'd5,
        A_LINE   = 3'd6,
        A_POS    = 3'd7
    } dtg_addr_e;

    localparam int H_LSB = 16;
    localparam int V_LSB = 0;

    localparam int CB_EN    = 0;
    localparam int CB_PCLK  = 28;
    localparam int CB_DELOW = 29;
    localparam int CB_VSHI  = 30;
    localparam int CB_HSHI  = 31;

    localparam int RB_IMM = 0;
    localparam int RB_VBL = 1;

    // boundary index inside the four timing registers
    localparam int BI_SYNC   = 0;
    localparam int BI_PORCH  = 1;
    localparam int BI_ACTIVE = 2;
    localparam int BI_TOTAL  = 3;
endpackage

// File: rtl/dtg_regs.sv
// Register file: pending and working (shadow) timing boundaries, control
// bits and reload logic. Assumes one register access per cycle and
// H_W, V_W no wider than 16.
module dtg_regs
    import dtg_pkg::*;
#(
    parameter int H_W = 12,
    parameter int V_W = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    input  logic                  frame_end,
    input  logic [H_W-1:0]        h_cnt,
    input  logic [V_W-1:0]        v_cnt,
    output logic [3:0][H_W-1:0]   work_h,
    output logic [3:0][V_W-1:0]   work_v,
    output logic [V_W-1:0]        work_line,
    output logic                  en,
    output logic                  hs_high,
    output logic                  vs_high,
    output logic                  de_low,
    output logic                  pclk_inv,
    output logic [31:0]           rdata
);
    localparam int NBND = 4;

    logic [3:0][H_W-1:0] pend_h;
    logic [3:0][V_W-1:0] pend_v;
    logic [V_W-1:0]      pend_line;
    logic                vbl_armed;
    logic                imm_load;
    logic                vbl_load;
    logic                load;

    assign imm_load = wr_en && (addr == A_RELOAD) && wdata[RB_IMM];
    assign vbl_load = vbl_armed && frame_end;
    assign load     = imm_load || vbl_load;

    generate
        for (genvar i = 0; i < NBND; i++) begin : g_bnd
            // Capture a pending boundary pair on a write to its address
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_h[i] <= '0;
                    pend_v[i] <= '0;
                end else if (wr_en && (addr == ADDR_W'(i))) begin
                    pend_h[i] <= wdata[H_LSB +: H_W];
                    pend_v[i] <= wdata[V_LSB +: V_W];
                end
            end

            // Copy the pending pair into the working set on a reload
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    work_h[i] <= '0;
                    work_v[i] <= '0;
                end else if (load) begin
                    work_h[i] <= pend_h[i];
                    work_v[i] <= pend_v[i];
                end
            end
        end
    endgenerate

    // Pending and working line-interrupt position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_line <= '0;
            work_line <= '0;
        end else begin
            if (wr_en && (addr == A_LINE))
                pend_line <= wdata[V_LSB +: V_W];
            if (load)
                work_line <= pend_line;
        end
    end

    // Control bits take effect immediately
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            hs_high  <= 1'b0;
            vs_high  <= 1'b0;
            de_low   <= 1'b0;
            pclk_inv <= 1'b0;
        end else if (wr_en && (addr == A_CTRL)) begin
            en       <= wdata[CB_EN];
            hs_high  <= wdata[CB_HSHI];
            vs_high  <= wdata[CB_VSHI];
            de_low   <= wdata[CB_DELOW];
            pclk_inv <= wdata[CB_PCLK];
        end
    end

    // Frame-end reload arm: set by software, cleared when consumed
    always_ff @(posedge clk) begin
        if (!rst_n)
            vbl_armed <= 1'b0;
        else if (wr_en && (addr == A_RELOAD) && wdata[RB_VBL])
            vbl_armed <= 1'b1;
        else if (vbl_load)
            vbl_armed <= 1'b0;
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            A_SYNC, A_PORCH, A_ACTIVE, A_TOTAL: begin
                rdata[H_LSB +: H_W] = pend_h[addr[1:0]];
                rdata[V_LSB +: V_W] = pend_v[addr[1:0]];
            end
            A_CTRL: begin
                rdata[CB_EN]    = en;
                rdata[CB_HSHI]  = hs_high;
                rdata[CB_VSHI]  = vs_high;
                rdata[CB_DELOW] = de_low;
                rdata[CB_PCLK]  = pclk_inv;
            end
            A_RELOAD: rdata[RB_VBL] = vbl_armed;
            A_LINE:   rdata[V_LSB +: V_W] = pend_line;
            default: begin
                rdata[H_LSB +: H_W] = h_cnt;
                rdata[V_LSB +: V_W] = v_cnt;
            end
        endcase
    end

    // R3
    imm_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imm_load |=> (work_h == $past(pend_h)) && (work_v == $past(pend_v)));

    // R4
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vbl_load && !(wr_en && addr == A_RELOAD)) |=> !vbl_armed);
endmodule

// File: rtl/dtg_counter.sv
// Column and row counters. Assumes the total boundaries may change at
// any edge; a count at or beyond the total wraps.
module dtg_counter #(
    parameter int H_W = 12,
    parameter int V_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [H_W-1:0] tot_h,
    input  logic [V_W-1:0] tot_v,
    output logic [H_W-1:0] h_cnt,
    output logic [V_W-1:0] v_cnt,
    output logic           frame_end
);
    logic h_wrap;
    logic v_wrap;

    assign h_wrap    = (h_cnt >= tot_h);
    assign v_wrap    = (v_cnt >= tot_v);
    assign frame_end = en && h_wrap && v_wrap;

    // Advance column each cycle, row on column wrap; hold at 0 when off
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (h_wrap) begin
            h_cnt <= '0;
            v_cnt <= v_wrap ? '0 : v_cnt + 1'b1;
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

    // R5
    h_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && h_cnt < tot_h) |=> (h_cnt == $past(h_cnt) + 1'b1) && (v_cnt == $past(v_cnt)));

    // R5
    h_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && h_cnt >= tot_h) |=> (h_cnt == '0));

    // R5
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (h_cnt == '0) && (v_cnt == '0));
endmodule

// File: rtl/dtg_outputs.sv
// Sync, data-enable and line-interrupt decode from the live counters and
// the working boundaries, with polarity applied. Purely combinational;
// the clock and reset only serve its checks.
module dtg_outputs
    import dtg_pkg::*;
#(
    parameter int H_W = 12,
    parameter int V_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [H_W-1:0]      h_cnt,
    input  logic [V_W-1:0]      v_cnt,
    input  logic [3:0][H_W-1:0] bnd_h,
    input  logic [3:0][V_W-1:0] bnd_v,
    input  logic [V_W-1:0]      line_pos,
    input  logic                hs_high,
    input  logic                vs_high,
    input  logic                de_low,
    output logic                hsync,
    output logic                vsync,
    output logic                de,
    output logic                line_irq
);
    logic hs_act;
    logic vs_act;
    logic h_vis;
    logic v_vis;
    logic de_act;

    // Active-level decode of the strobes
    always_comb begin
        hs_act = en && (h_cnt <= bnd_h[BI_SYNC]);
        vs_act = en && (v_cnt <= bnd_v[BI_SYNC]);
        h_vis  = (h_cnt > bnd_h[BI_PORCH]) && (h_cnt <= bnd_h[BI_ACTIVE]);
        v_vis  = (v_cnt > bnd_v[BI_PORCH]) && (v_cnt <= bnd_v[BI_ACTIVE]);
        de_act = en && h_vis && v_vis;
    end

    // Polarity application and line interrupt
    always_comb begin
        hsync    = hs_high ? hs_act : !hs_act;
        vsync    = vs_high ? vs_act : !vs_act;
        de       = de_low ? !de_act : de_act;
        line_irq = en && (h_cnt == '0) && (v_cnt == line_pos);
    end

    // R8
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (hsync == !hs_high) && (vsync == !vs_high) && (de == de_low));

    // R10
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_irq |=> !line_irq);
endmodule

// File: rtl/disp_timing_gen.sv
// Top of the programmable display timing generator. Ties the register
// file, counters and output decode together. Assumes a single clock
// domain (the pixel clock) and synchronous active-low reset.
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int H_W = 12,
    parameter int V_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              pclk_invert,
    output logic [H_W-1:0]    pix_x,
    output logic [V_W-1:0]    pix_y,
    output logic              line_irq
);
    logic [3:0][H_W-1:0] work_h;
    logic [3:0][V_W-1:0] work_v;
    logic [V_W-1:0]      work_line;
    logic                en;
    logic                hs_high;
    logic                vs_high;
    logic                de_low;
    logic                frame_end;
    logic [H_W-1:0]      h_cnt;
    logic [V_W-1:0]      v_cnt;

    dtg_regs #(.H_W(H_W), .V_W(V_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .frame_end (frame_end),
        .h_cnt     (h_cnt),
        .v_cnt     (v_cnt),
        .work_h    (work_h),
        .work_v    (work_v),
        .work_line (work_line),
        .en        (en),
        .hs_high   (hs_high),
        .vs_high   (vs_high),
        .de_low    (de_low),
        .pclk_inv  (pclk_invert),
        .rdata     (reg_rdata)
    );

    dtg_counter #(.H_W(H_W), .V_W(V_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tot_h     (work_h[BI_TOTAL]),
        .tot_v     (work_v[BI_TOTAL]),
        .h_cnt     (h_cnt),
        .v_cnt     (v_cnt),
        .frame_end (frame_end)
    );

    dtg_outputs #(.H_W(H_W), .V_W(V_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .h_cnt    (h_cnt),
        .v_cnt    (v_cnt),
        .bnd_h    (work_h),
        .bnd_v    (work_v),
        .line_pos (work_line),
        .hs_high  (hs_high),
        .vs_high  (vs_high),
        .de_low   (de_low),
        .hsync    (hsync),
        .vsync    (vsync),
        .de       (de),
        .line_irq (line_irq)
    );

    assign pix_x = h_cnt;
    assign pix_y = v_cnt;
endmodule

// File: tb/disp_timing_gen_tb.sv
module disp_timing_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hsync, vsync, de, pclk_invert, line_irq;
    logic [11:0] pix_x;
    logic [10:0] pix_y;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // configurations: [0]=sync [1]=porch [2]=active [3]=total, [4]=line
    int ah[4] = '{1, 3, 7, 9};
    int av[5] = '{0, 1, 4, 5, 5};
    int bh[4] = '{0, 2, 5, 7};
    int bv[5] = '{1, 2, 4, 4, 2};
    int hp, vp, dp;

    always #10 clk = ~clk;

    disp_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync(hsync),
        .vsync(vsync), .de(de), .pclk_invert(pclk_invert), .pix_x(pix_x),
        .pix_y(pix_y), .line_irq(line_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // write one register; returns at the falling edge after the write edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input string req, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    function automatic logic [31:0] pack(input int h, input int v);
        return (32'(h) << 16) | 32'(v);
    endfunction

    // sweep n cycles from k=0; config A before index sw, config B after
    task automatic sweep(input int n, input int sw);
        int hh[4];
        int vv[5];
        reg_addr = 3'd7;
        for (int k = 0; k < n; k++) begin
            int kk, x, y;
            logic hs, vs, dd, irq;
            if (k < sw) begin hh = ah; vv = av; kk = k; end
            else begin hh = bh; vv = bv; kk = k - sw; end
            x = kk % (hh[3] + 1);
            y = (kk / (hh[3] + 1)) % (vv[3] + 1);
            hs = (x <= hh[0]);
            vs = (y <= vv[0]);
            dd = (x > hh[1]) && (x <= hh[2]) && (y > vv[1]) && (y <= vv[2]);
            irq = (x == 0) && (y == vv[4]);
            #1;
            chk("R5 column", 32'(pix_x), 32'(x));
            chk("R5 row", 32'(pix_y), 32'(y));
            chk("R6 hsync", 32'(hsync), 32'(hp ? hs : !hs));
            chk("R6 vsync", 32'(vsync), 32'(vp ? vs : !vs));
            chk("R7 de", 32'(de), 32'(dp ? !dd : dd));
            chk("R10 line irq", 32'(line_irq), 32'(irq));
            chk("R11 position", reg_rdata, pack(x, y));
            @(negedge clk);
        end
    endtask

    task automatic check_idle(input int n);
        for (int i = 0; i < n; i++) begin
            #1;
            chk("R8 idle hsync", 32'(hsync), 32'(!hp));
            chk("R8 idle vsync", 32'(vsync), 32'(!vp));
            chk("R8 idle de", 32'(de), 32'(dp));
            chk("R5 held", pack(pix_x, pix_y), 32'd0);
            chk("R10 idle irq", 32'(line_irq), 32'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        hp = 0; vp = 0; dp = 0;
        for (int a = 0; a < 7; a++) rd(3'(a), "R12 reset read", 32'd0);
        rd(3'd7, "R12 reset position", 32'd0);
        chk("R12 reset hsync", 32'(hsync), 32'd1);
        chk("R12 reset de", 32'(de), 32'd0);
        chk("R9 reset pclk", 32'(pclk_invert), 32'd0);

        // R1 program config A, read back pending values
        for (int i = 0; i < 4; i++) wr(3'(i), pack(ah[i], av[i]));
        wr(3'd6, 32'(av[4]));
        for (int i = 0; i < 4; i++) rd(3'(i), "R1 readback", pack(ah[i], av[i]));
        rd(3'd6, "R1 line readback", 32'(av[4]));
        wr(3'd5, 32'h1);           // R3 immediate reload
        rd(3'd5, "R3 imm bit reads 0", 32'd0);
        hp = 1; vp = 1; dp = 0;
        wr(3'd4, 32'hC000_0001);   // enable, hsync/vsync active-high
        sweep(130, 1000);          // R5 R6 R7 R10 R11 two-plus frames

        // R8 disable: outputs at inactive level, counters held
        wr(3'd4, 32'hC000_0000);
        @(negedge clk);
        check_idle(4);

        // R8 R9 inverted polarities and pixel clock flag
        hp = 0; vp = 0; dp = 1;
        wr(3'd4, 32'h3000_0001);
        chk("R9 pclk invert", 32'(pclk_invert), 32'd1);
        rd(3'd4, "R1 ctrl readback", 32'h3000_0001);
        sweep(70, 1000);

        // R2 R4 frame-end reload of config B
        wr(3'd4, 32'h0);
        @(negedge clk);
        for (int i = 0; i < 4; i++) wr(3'(i), pack(bh[i], bv[i]));
        wr(3'd6, 32'(bv[4]));
        wr(3'd5, 32'h2);
        rd(3'd5, "R4 armed", 32'h2);
        hp = 1; vp = 1; dp = 0;
        wr(3'd4, 32'hC000_0001);
        sweep(60 + 90, 60);        // R2 old timing for one frame, then new
        rd(3'd5, "R4 arm cleared", 32'd0);
        chk("R9 pclk clear", 32'(pclk_invert), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule